// File: doc/BRIEF.md
# Gateless Serial Load/Store Bit Processor

This block is a processor core whose datapath holds no logic gate at all. Its whole architectural state is a program counter, an instruction register and a single one-bit holding register. It knows two operations. A Load copies one memory bit into the holding register. A Store writes the holding register back to one memory bit. Instructions are read one bit per cycle from a bit-addressable memory, at a program counter that only ever counts up by one.

Any logic function is computed by the program itself, through self-modifying code. The program stores operand bits into the low address bits of a Load placed further ahead. When that Load is fetched, its address points at an entry of a truth table kept in memory. The memory and the program live outside the block. The core drives a single-port memory that takes one access per cycle and returns read data one cycle after the request.

Top module: `lsbit_core`

## Requirements
- R1: An instruction is INSTR_W = ADDR_W+1 bits, fetched from consecutive addresses. The first bit fetched (instruction bit 0) is the opcode: 0 = Load, 1 = Store. Instruction bit i, for i from 1 to INSTR_W-1, is address bit INSTR_W-1-i, so the address arrives most significant bit first.
- R2: Each fetch cycle issues exactly one read at the program counter, which then advances by one. From 2^ADDR_W-1 it wraps to 0. No other change of the counter exists.
- R3: The INSTR_W fetch reads are followed by exactly one cycle with neither read nor write. The execute access comes in the cycle after that.
- R4: A Load reads the instruction's address. The returned bit becomes the holding register, and one cycle without any access follows before the next fetch begins.
- R5: A Store is a single write of the holding register to the instruction's address. The first fetch read of the next instruction comes in the very next cycle.
- R6: Reset sets the program counter to 0 and the holding register to 0, and enters the fetch state. While reset is held, the block presents a read at address 0 and no write. A Store executed before any Load writes 0.
- R7: An all-zero instruction word executes as a Load from address 0.
- R8: A Store into a bit of a later instruction changes that instruction when it is fetched. Storing operand A into instruction bit INSTR_W-1 and operand B into bit INSTR_W-2 of a Load whose other address bits hold a 4-aligned base makes it read the table entry at base + 2*B + A.
- R9: The memory sees at most one access per cycle: read request and write request are never both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | ADDR_W | Bit address of the current memory access |
| memRe | output | 1 | Read request; data is returned on memRdata one cycle later |
| memWe | output | 1 | Write request for memWdata at memAddr |
| memWdata | output | 1 | Bit to write (the holding register) |
| memRdata | input | 1 | Read data, valid the cycle after a read request |

## Verification
On every cycle, the embedded properties check that the counter only steps by one, that reads and writes never coincide, that the gap and execute slots follow a complete fetch, and that the holding register changes only on a Load's capture cycle. Only the scenarios can show that the right bit reaches the holding register and lands at the right address. The same holds for a stored operand changing a later instruction, and for the truth-table lookup producing the intended function. The bench therefore sweeps all sixteen two-input functions over all four operand pairs. It also runs an all-zero memory through a full counter wrap, and runs a Store straight after reset.

// File: rtl/lsbit_pkg.sv
package lsbit_pkg;

  // Sequencer phases of one instruction
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,  // one instruction bit read per cycle
    ST_DRAIN = 2'd1,  // last fetched bit arrives, no access
    ST_EXEC  = 2'd2,  // the single data access
    ST_LWAIT = 2'd3   // load data arrives, no access
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic pcInc;     // advance program counter
    logic irShift;   // shift returned bit into instruction register
    logic holdLoad;  // capture returned bit into holding register
    logic selExec;   // address mux: instruction address instead of PC
  } ctlStrobe_t;

endpackage

// File: rtl/lsbit_ctrl.sv
module lsbit_ctrl
  import lsbit_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       irOp,
  output ctlStrobe_t stb,
  output logic       memRe,
  output logic       memWe
);

  localparam int INSTR_W = ADDR_W + 1;
  localparam int CNT_W   = $clog2(INSTR_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(INSTR_W - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_FETCH;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

  always_comb begin
    stateNext    = state;
    bitCntNext   = bitCnt;
    stb          = '0;
    memRe        = 1'b0;
    memWe        = 1'b0;
    unique case (state)
      ST_FETCH: begin
        memRe       = 1'b1;
        stb.pcInc   = 1'b1;
        stb.irShift = (bitCnt != '0);
        if (bitCnt == LAST_BIT) begin
          stateNext  = ST_DRAIN;
          bitCntNext = '0;
        end else begin
          bitCntNext = bitCnt + 1'b1;
        end
      end
      ST_DRAIN: begin
        stb.irShift = 1'b1;
        stateNext   = ST_EXEC;
      end
      ST_EXEC: begin
        stb.selExec = 1'b1;
        if (irOp) begin
          memWe     = 1'b1;
          stateNext = ST_FETCH;
        end else begin
          memRe     = 1'b1;
          stateNext = ST_LWAIT;
        end
      end
      ST_LWAIT: begin
        stb.holdLoad = 1'b1;
        stateNext    = ST_FETCH;
      end
      default: stateNext = ST_FETCH;
    endcase
  end

  // R9: single-port memory, never read and write together
  p_one_access_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R3: the gap cycle is entered only after the final fetch bit
  p_full_fetch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |-> ($past(state) == ST_FETCH && $past(bitCnt) == LAST_BIT));

  // R3: gap is followed by an access in the execute slot
  p_drain_exec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |=> (state == ST_EXEC && (memRe || memWe)));

  // R4: a load execute is followed by a silent capture cycle
  p_load_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC && !irOp) |=> (state == ST_LWAIT && !memRe && !memWe));

  // R5: after a store, the next instruction starts at its first bit
  p_store_then_fetch_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (state == ST_FETCH && bitCnt == '0 && memRe));

endmodule

// File: rtl/lsbit_dpath.sv
module lsbit_dpath
  import lsbit_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWdata,
  output logic              irOp
);

  localparam int INSTR_W = ADDR_W + 1;

  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] ir;
  logic               holdBit;
  logic [ADDR_W-1:0]  execAddr;

  // Program counter: increment only, natural wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pc <= '0;
    else if (stb.pcInc) pc <= pc + 1'b1;
  end

  // Instruction register: bits enter at the top, first bit ends at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ir <= '0;
    else if (stb.irShift) ir <= {memRdata, ir[INSTR_W-1:1]};
  end

  // Holding register, the only data storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdBit <= 1'b0;
    else if (stb.holdLoad) holdBit <= memRdata;
  end

  // Address field is sent most significant bit first: reverse it
  for (genvar j = 0; j < ADDR_W; j++) begin : g_addrRev
    assign execAddr[j] = ir[INSTR_W-1-j];
  end

  assign irOp     = ir[0];
  assign memAddr  = stb.selExec ? execAddr : pc;
  assign memWdata = holdBit;

  // R2: the counter moves by exactly one or not at all
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pc != $past(pc)) |-> (pc == ADDR_W'($past(pc) + 1)));

  // R4: holding register changes only on a load capture
  p_hold_only_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.holdLoad |=> $stable(holdBit));

  // R1: the decoded instruction stays put during its execute slot
  p_ir_frozen_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.selExec |=> $stable(ir));

  // R2: fetch reads always go to the program counter
  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.pcInc |-> (memAddr == pc));

endmodule

// File: rtl/lsbit_core.sv
module lsbit_core #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic              memWdata,
  input  logic              memRdata
);

  lsbit_pkg::ctlStrobe_t stb;
  logic irOp;

  lsbit_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .irOp  (irOp),
    .stb   (stb),
    .memRe (memRe),
    .memWe (memWe)
  );

  lsbit_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .irOp     (irOp)
  );

endmodule

// File: tb/lsbit_core_test.sv
`timescale 1ns/1ps
module lsbit_core_test;

  localparam int ADDR_W = 6;
  localparam int IW     = ADDR_W + 1;
  localparam int MEM_N  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic memRe, memWe, memWdata;
  logic memRdata = 1'b0;
  logic mem [0:MEM_N-1];

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit sawWrap = 0;

  always #10 clk = ~clk;  // 50 MHz

  lsbit_core #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata)
  );

  // Single-port bit memory, read data one cycle after the request
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Cycle-level instruction model built from the requirements
  int mPhase = 0;
  int mK = 0;
  int mPc = 0;
  logic mHold = 1'b0;
  logic [IW-1:0] mInstr = '0;

  always @(negedge clk) begin
    if (!rstN) begin
      mPhase = 0; mK = 0; mPc = 0; mHold = 1'b0;
    end else begin
      logic [ADDR_W-1:0] a;
      chk(!(memRe && memWe), "R9 single access", int'(memRe && memWe), 0);
      case (mPhase)
        0: begin
          chk(memRe && !memWe && memAddr == ADDR_W'(mPc), "R2 fetch read at pc",
              int'(memAddr), mPc);
          mInstr[mK] = mem[mPc];
          if (mPc == MEM_N - 1) sawWrap = 1;
          mPc = (mPc + 1) % MEM_N;
          if (mK == IW - 1) begin mPhase = 1; mK = 0; end
          else mK++;
        end
        1: begin
          chk(!memRe && !memWe, "R3 gap after fetch", int'({memRe, memWe}), 0);
          mPhase = 2;
        end
        2: begin
          for (int j = 0; j < ADDR_W; j++) a[j] = mInstr[IW-1-j];
          if (mInstr == '0)
            chk(memRe && !memWe && memAddr == '0, "R7 zero word loads address 0",
                int'(memAddr), 0);
          if (!mInstr[0]) begin
            chk(memRe && !memWe && memAddr == a, "R1 R4 load address",
                int'(memAddr), int'(a));
            mHold = mem[a];
            mPhase = 3;
          end else begin
            chk(memWe && !memRe && memAddr == a, "R1 R5 store address",
                int'(memAddr), int'(a));
            chk(memWdata == mHold, "R4 R5 stored holding bit", int'(memWdata), int'(mHold));
            mPhase = 0;
          end
        end
        default: begin
          chk(!memRe && !memWe, "R4 load capture cycle idle", int'({memRe, memWe}), 0);
          mPhase = 0;
        end
      endcase
    end
  end

  task automatic clearMem();
    for (int i = 0; i < MEM_N; i++) mem[i] = 1'b0;
  endtask

  task automatic putInstr(input int base, input bit op, input int addr);
    mem[base] = op;
    for (int i = 1; i < IW; i++) mem[base + i] = addr[IW-1-i];
  endtask

  task automatic enterReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
  endtask

  task automatic leaveReset();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clearMem();
    repeat (2) @(negedge clk);
    // R6: outputs while reset is held
    chk(memRe && !memWe && memAddr == '0, "R6 reset state", int'({memRe, memWe, memAddr}),
        int'({1'b1, 1'b0, 6'd0}));

    // R6: store before any load writes 0 (all-ones word = Store 63)
    clearMem();
    putInstr(0, 1'b1, 63);
    mem[63] = 1'b1;
    leaveReset();
    run(12);
    enterReset();
    chk(mem[63] == 1'b0, "R6 holding register resets to 0", int'(mem[63]), 0);

    // R8 R1: every two-input function over every operand pair
    for (int f = 0; f < 16; f++) begin
      for (int b = 0; b < 2; b++) begin
        for (int a = 0; a < 2; a++) begin
          enterReset();
          clearMem();
          putInstr(0,  1'b0, 60);        // load A
          putInstr(7,  1'b1, 34);        // A into last bit of slot 4
          putInstr(14, 1'b0, 61);        // load B
          putInstr(21, 1'b1, 33);        // B into next-to-last bit of slot 4
          putInstr(28, 1'b0, 56);        // table load, base 56
          putInstr(35, 1'b1, 62);        // result
          putInstr(42, 1'b0, 63);
          putInstr(49, 1'b0, 63);
          for (int k = 0; k < 4; k++) mem[56 + k] = f[k];
          mem[60] = a[0];
          mem[61] = b[0];
          mem[62] = ~f[a + 2*b];
          leaveReset();
          run(60);
          enterReset();
          chk(mem[34] == a[0], "R8 operand A in later instruction", int'(mem[34]), a);
          chk(mem[33] == b[0], "R8 operand B in later instruction", int'(mem[33]), b);
          chk(mem[62] == f[a + 2*b], "R8 table lookup result", int'(mem[62]),
              int'(f[a + 2*b]));
        end
      end
    end

    // R2 R7: all-zero memory runs through a counter wrap
    enterReset();
    clearMem();
    sawWrap = 0;
    leaveReset();
    run(150);
    enterReset();
    chk(sawWrap, "R2 program counter wrapped to 0", int'(sawWrap), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule